// File: doc/BRIEF.md
# Two-Stage Access Permission Checker

This block judges whether one memory access is legal when a virtualized core translates addresses in two stages: a guest stage that maps guest virtual to guest physical addresses, then a host (G) stage that maps guest physical to host physical addresses. The page walker supplies the leaf permission bits of both stages. The core supplies the access type, its current privilege and virtualization state, the execute-readable and user-access controls, and a flag marking the hypervisor's virtual-machine load/store instructions. One cycle later the block returns one verdict: illegal instruction, guest-stage (G) fault, first-stage fault, or pass.

The hypervisor load/store instructions run in machine mode or non-virtual supervisor mode. They always use both stages. A control input selects the privilege that the first stage checks with. A second control input decides whether non-virtual user mode may issue them. G-stage checks always treat the access as a user access. The host execute-readable control applies to both stages. The guest execute-readable control applies only to the first stage.

Top module: `twostage_perm_checker`

## Requirements
- R1: Every verdict appears on the outputs exactly one clock after the request is sampled. `rsp_valid` follows `req_valid` by one cycle. When `req_valid` is low, all three flags are 0 in the following cycle. After reset, all outputs are 0.
- R2: A hypervisor load/store (`req_hv_insn`=1) is legal in machine mode (`req_priv`=3) and in non-virtual supervisor mode (`req_priv`=1). In non-virtual user mode (`req_priv`=0) it is legal only when `hv_user_ok`=1. It is always illegal when `req_virt`=1. An illegal request raises `rsp_illegal` and no fault flag.
- R3: A legal hypervisor load/store checks both stages even when `req_virt`=0. Its first stage uses user privilege when `hv_guest_priv_s`=0 and supervisor privilege when `hv_guest_priv_s`=1.
- R4: The G stage treats every access as a user access. A G-stage page whose U bit is clear fails every access type.
- R5: A load from a page that is execute-only (X set, R clear) passes the first stage when `mxr_host` or `mxr_guest` is 1. It passes the G stage only when `mxr_host` is 1.
- R6: In both stages, a load needs R (apart from the R5 cases), a store needs W, and a fetch needs X. A page with W set and R clear faults on every access type. Access codes are load=0, store=1, fetch=2. Permission vectors are {U,X,W,R} with R at bit 0.
- R7: A first-stage user access needs the U bit. A first-stage supervisor access to a page with U set is allowed for loads and stores only when `sum_guest`=1. A first-stage supervisor fetch from a page with U set always fails.
- R8: A first-stage failure raises `rsp_pfault` and hides any G-stage failure. A G-stage failure alone raises `rsp_gfault`.
- R9: A request that is not translated (`req_virt`=0 and `req_hv_insn`=0, or machine mode without a hypervisor instruction) raises no flag.
- R10: At most one of the three flags is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Core is running a guest |
| req_hv_insn | input | 1 | Request comes from a hypervisor virtual-machine load/store |
| hv_user_ok | input | 1 | Non-virtual user mode may issue hypervisor load/store |
| hv_guest_priv_s | input | 1 | First-stage privilege for hypervisor load/store (1 = supervisor) |
| mxr_host | input | 1 | Host execute-readable control, applies to both stages |
| mxr_guest | input | 1 | Guest execute-readable control, applies to the first stage only |
| sum_guest | input | 1 | Guest supervisor may access user pages |
| s1_perm | input | 4 | First-stage leaf bits {U,X,W,R} |
| g_perm | input | 4 | G-stage leaf bits {U,X,W,R} |
| rsp_valid | output | 1 | Verdict present |
| rsp_illegal | output | 1 | Illegal-instruction verdict |
| rsp_gfault | output | 1 | Guest-stage page fault |
| rsp_pfault | output | 1 | First-stage page fault |

## Verification
The stimulus crosses the three access types with permission vectors that differ in one bit, so that a missing R, W, X or U test is seen in a single verdict. Execute-only pages are loaded under each combination of the two execute-readable controls, which separates the host control from the guest control. Hypervisor instructions are issued from every privilege and virtualization pair, with both values of the privilege-select control, to separate illegal-instruction cases from first-stage privilege choices. Pages that are bad in both stages show which fault takes priority, and idle cycles carrying bad inputs show that no verdict leaks out.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    localparam logic [1:0] PRIV_USER = 2'd0;
    localparam logic [1:0] PRIV_SUP  = 2'd1;
    localparam logic [1:0] PRIV_MACH = 2'd3;

    localparam int PERM_W = 4;

    typedef struct packed {
        logic u;
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic valid;
        logic illegal;
        logic gfault;
        logic pfault;
    } verdict_t;
endpackage

// File: rtl/pchk_hv_gate.sv
module pchk_hv_gate
    import pchk_pkg::*;
(
    input  logic       hv_insn,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       user_ok,
    input  logic       guest_priv_s,
    output logic       illegal,
    output logic       translate,
    output logic       s1_sup
);
    logic user_block;

    always_comb begin
        user_block = (priv == PRIV_USER) && !user_ok;
        illegal    = hv_insn && (virt || user_block);
        translate  = hv_insn || (virt && (priv != PRIV_MACH));
        if (hv_insn) s1_sup = guest_priv_s;
        else         s1_sup = (priv == PRIV_SUP);
    end
endmodule

// File: rtl/pchk_stage_rules.sv
module pchk_stage_rules
    import pchk_pkg::*;
#(
    parameter bit GUEST_STAGE = 1'b0
)(
    input  perm_t      perm,
    input  logic [1:0] acc,
    input  logic       sup,
    input  logic       mxr,
    input  logic       sum,
    output logic       fail
);
    logic type_ok;
    logic reserved;
    logic priv_ok;

    always_comb begin
        reserved = perm.w && !perm.r;
        unique case (acc)
            ACC_LOAD:  type_ok = perm.r || (perm.x && mxr);
            ACC_STORE: type_ok = perm.w;
            ACC_FETCH: type_ok = perm.x;
            default:   type_ok = 1'b0;
        endcase
    end

    generate
        if (GUEST_STAGE) begin : g_host_rule
            always_comb priv_ok = perm.u;
        end else begin : g_first_rule
            always_comb begin
                if (!sup)               priv_ok = perm.u;
                else if (!perm.u)       priv_ok = 1'b1;
                else if (acc == ACC_FETCH) priv_ok = 1'b0;
                else                    priv_ok = sum;
            end
        end
    endgenerate

    assign fail = reserved || !type_ok || !priv_ok;
endmodule

// File: rtl/twostage_perm_checker.sv
module twostage_perm_checker
    import pchk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_acc,
    input  logic [1:0] req_priv,
    input  logic       req_virt,
    input  logic       req_hv_insn,
    input  logic       hv_user_ok,
    input  logic       hv_guest_priv_s,
    input  logic       mxr_host,
    input  logic       mxr_guest,
    input  logic       sum_guest,
    input  logic [3:0] s1_perm,
    input  logic [3:0] g_perm,
    output logic       rsp_valid,
    output logic       rsp_illegal,
    output logic       rsp_gfault,
    output logic       rsp_pfault
);
    logic illegal_c, translate_c, s1_sup_c;
    logic s1_fail_c, g_fail_c;
    verdict_t vd_d, vd_q;

    pchk_hv_gate u_gate (
        .hv_insn      (req_hv_insn),
        .priv         (req_priv),
        .virt         (req_virt),
        .user_ok      (hv_user_ok),
        .guest_priv_s (hv_guest_priv_s),
        .illegal      (illegal_c),
        .translate    (translate_c),
        .s1_sup       (s1_sup_c)
    );

    pchk_stage_rules #(.GUEST_STAGE(1'b0)) u_first (
        .perm (perm_t'(s1_perm)),
        .acc  (req_acc),
        .sup  (s1_sup_c),
        .mxr  (mxr_host || mxr_guest),
        .sum  (sum_guest),
        .fail (s1_fail_c)
    );

    pchk_stage_rules #(.GUEST_STAGE(1'b1)) u_host (
        .perm (perm_t'(g_perm)),
        .acc  (req_acc),
        .sup  (1'b0),
        .mxr  (mxr_host),
        .sum  (1'b0),
        .fail (g_fail_c)
    );

    always_comb begin
        vd_d         = '0;
        vd_d.valid   = req_valid;
        if (req_valid) begin
            vd_d.illegal = illegal_c;
            vd_d.pfault  = !illegal_c && translate_c && s1_fail_c;
            vd_d.gfault  = !illegal_c && translate_c && !s1_fail_c && g_fail_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vd_q <= '0;
        else        vd_q <= vd_d;
    end

    assign rsp_valid   = vd_q.valid;
    assign rsp_illegal = vd_q.illegal;
    assign rsp_gfault  = vd_q.gfault;
    assign rsp_pfault  = vd_q.pfault;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_illegal || rsp_gfault || rsp_pfault));

    assert_virt_hv_illegal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hv_insn && req_virt) |=> (rsp_illegal && !rsp_pfault && !rsp_gfault));

    assert_host_needs_u_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_virt && !req_hv_insn && req_priv != PRIV_MACH && !g_perm[3])
            |=> (rsp_gfault || rsp_pfault));

    assert_untranslated_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_virt && !req_hv_insn) |=> !(rsp_illegal || rsp_gfault || rsp_pfault));

    assert_one_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_illegal, rsp_gfault, rsp_pfault}));

    assert_flag_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_illegal || rsp_gfault || rsp_pfault) |-> rsp_valid);
endmodule

// File: tb/twostage_perm_checker_tb.sv
module twostage_perm_checker_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_virt = 0, req_hv_insn = 0, hv_user_ok = 0, hv_guest_priv_s = 0;
    logic mxr_host = 0, mxr_guest = 0, sum_guest = 0;
    logic [1:0] req_acc = 0, req_priv = 0;
    logic [3:0] s1_perm = 0, g_perm = 0;
    logic rsp_valid, rsp_illegal, rsp_gfault, rsp_pfault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    twostage_perm_checker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acc(req_acc),
        .req_priv(req_priv), .req_virt(req_virt), .req_hv_insn(req_hv_insn),
        .hv_user_ok(hv_user_ok), .hv_guest_priv_s(hv_guest_priv_s),
        .mxr_host(mxr_host), .mxr_guest(mxr_guest), .sum_guest(sum_guest),
        .s1_perm(s1_perm), .g_perm(g_perm), .rsp_valid(rsp_valid),
        .rsp_illegal(rsp_illegal), .rsp_gfault(rsp_gfault), .rsp_pfault(rsp_pfault)
    );

    function automatic logic stage_fail(logic [3:0] p, logic [1:0] a, logic sup,
                                        logic mx, logic sm);
        logic ok;
        if (p[1] && !p[0]) return 1'b1;
        case (a)
            2'd0: ok = p[0] || (p[2] && mx);
            2'd1: ok = p[1];
            2'd2: ok = p[2];
            default: ok = 1'b0;
        endcase
        if (!ok) return 1'b1;
        if (!sup) return !p[3];
        if (!p[3]) return 1'b0;
        if (a == 2'd2) return 1'b1;
        return !sm;
    endfunction

    function automatic logic [3:0] model();
        logic ill, tr, sup, f1, fg;
        if (!req_valid) return 4'b0000;
        ill = req_hv_insn && (req_virt || (req_priv == 2'd0 && !hv_user_ok));
        if (ill) return 4'b1100;
        tr  = req_hv_insn || (req_virt && req_priv != 2'd3);
        if (!tr) return 4'b1000;
        sup = req_hv_insn ? hv_guest_priv_s : (req_priv == 2'd1);
        f1  = stage_fail(s1_perm, req_acc, sup, mxr_host | mxr_guest, sum_guest);
        fg  = stage_fail(g_perm, req_acc, 1'b0, mxr_host, 1'b0);
        if (f1) return 4'b1001;
        if (fg) return 4'b1010;
        return 4'b1000;
    endfunction

    task automatic drive(input string tag, input logic v, input logic [1:0] acc,
                         input logic [1:0] prv, input logic vt, input logic hv,
                         input logic hu, input logic gps, input logic mh,
                         input logic mg, input logic sm, input logic [3:0] p1,
                         input logic [3:0] pg);
        item_t it;
        @(negedge clk);
        req_valid = v; req_acc = acc; req_priv = prv; req_virt = vt; req_hv_insn = hv;
        hv_user_ok = hu; hv_guest_priv_s = gps; mxr_host = mh; mxr_guest = mg;
        sum_guest = sm; s1_perm = p1; g_perm = pg;
        it.exp = model();
        it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: pops one expected verdict per edge, 2 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && sb.size() > 0) begin
                item_t it;
                logic [3:0] got;
                it  = sb.pop_front();
                got = {rsp_valid, rsp_illegal, rsp_gfault, rsp_pfault};
                checks++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s: got %b expected %b", it.tag, got, it.exp);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if ({rsp_valid, rsp_illegal, rsp_gfault, rsp_pfault} !== 4'b0000) begin
            fails++;
            $display("FAIL R1 reset: got %b expected 0000",
                     {rsp_valid, rsp_illegal, rsp_gfault, rsp_pfault});
        end
        @(negedge clk);
        rst_n = 1'b1;

        //      tag    v  acc  prv  vt hv hu gps mh mg sm s1      g
        drive("R9 nonvirt",  1, 2'd0, 2'd1, 0, 0, 0, 0, 0, 0, 0, 4'b0000, 4'b0000);
        drive("R9 mach",     1, 2'd1, 2'd3, 1, 0, 0, 0, 0, 0, 0, 4'b0000, 4'b0000);
        drive("R1 idle",     0, 2'd0, 2'd0, 1, 1, 0, 0, 0, 0, 0, 4'b0000, 4'b0000);
        drive("R2 U no ok",  1, 2'd0, 2'd0, 0, 1, 0, 0, 0, 0, 0, 4'b1001, 4'b1001);
        drive("R2 U ok",     1, 2'd0, 2'd0, 0, 1, 1, 0, 0, 0, 0, 4'b1001, 4'b1001);
        drive("R2 M",        1, 2'd1, 2'd3, 0, 1, 0, 0, 0, 0, 0, 4'b1011, 4'b1011);
        drive("R2 S",        1, 2'd1, 2'd1, 0, 1, 0, 0, 0, 0, 0, 4'b1011, 4'b1011);
        drive("R2 VS",       1, 2'd0, 2'd1, 1, 1, 1, 0, 0, 0, 0, 4'b0000, 4'b0000);
        drive("R2 VU ok",    1, 2'd0, 2'd0, 1, 1, 1, 0, 0, 0, 0, 4'b1001, 4'b1001);
        drive("R3 gps0",     1, 2'd0, 2'd3, 0, 1, 0, 0, 0, 0, 0, 4'b0011, 4'b1011);
        drive("R3 gps1",     1, 2'd0, 2'd3, 0, 1, 0, 1, 0, 0, 0, 4'b0011, 4'b1011);
        drive("R3 gstage",   1, 2'd0, 2'd1, 0, 1, 0, 1, 0, 0, 0, 4'b0011, 4'b1000);
        drive("R4 no U",     1, 2'd0, 2'd1, 1, 0, 0, 0, 0, 0, 0, 4'b0011, 4'b0011);
        drive("R4 U ok",     1, 2'd0, 2'd1, 1, 0, 0, 0, 0, 0, 0, 4'b0011, 4'b1011);
        drive("R5 guest",    1, 2'd0, 2'd1, 1, 0, 0, 0, 0, 1, 0, 4'b0100, 4'b1100);
        drive("R5 host",     1, 2'd0, 2'd1, 1, 0, 0, 0, 1, 0, 0, 4'b0100, 4'b1100);
        drive("R5 none",     1, 2'd0, 2'd1, 1, 0, 0, 0, 0, 0, 0, 4'b0100, 4'b1111);
        drive("R6 st noW",   1, 2'd1, 2'd1, 1, 0, 0, 0, 0, 0, 0, 4'b0001, 4'b1111);
        drive("R6 st W",     1, 2'd1, 2'd1, 1, 0, 0, 0, 0, 0, 0, 4'b0011, 4'b1011);
        drive("R6 fe noX",   1, 2'd2, 2'd1, 1, 0, 0, 0, 0, 0, 0, 4'b0011, 4'b1111);
        drive("R6 fe X",     1, 2'd2, 2'd1, 1, 0, 0, 0, 0, 0, 0, 4'b0100, 4'b1100);
        drive("R6 WnoR s1",  1, 2'd1, 2'd1, 1, 0, 0, 0, 1, 1, 0, 4'b0110, 4'b1111);
        drive("R6 WnoR g",   1, 2'd0, 2'd1, 1, 0, 0, 0, 1, 0, 0, 4'b0011, 4'b1110);
        drive("R6 g store",  1, 2'd1, 2'd1, 1, 0, 0, 0, 0, 0, 0, 4'b0011, 4'b1001);
        drive("R7 VU noU",   1, 2'd0, 2'd0, 1, 0, 0, 0, 0, 0, 0, 4'b0001, 4'b1111);
        drive("R7 VU U",     1, 2'd0, 2'd0, 1, 0, 0, 0, 0, 0, 0, 4'b1001, 4'b1111);
        drive("R7 VS sum0",  1, 2'd0, 2'd1, 1, 0, 0, 0, 0, 0, 0, 4'b1001, 4'b1111);
        drive("R7 VS sum1",  1, 2'd1, 2'd1, 1, 0, 0, 0, 0, 0, 1, 4'b1011, 4'b1111);
        drive("R7 VS fetch", 1, 2'd2, 2'd1, 1, 0, 0, 0, 0, 0, 1, 4'b1100, 4'b1111);
        drive("R8 both bad", 1, 2'd1, 2'd1, 1, 0, 0, 0, 0, 0, 0, 4'b0001, 4'b0001);
        drive("R10 gonly",   1, 2'd2, 2'd0, 1, 0, 0, 0, 0, 0, 0, 4'b1100, 4'b1011);
        drive("R1 idle2",    0, 2'd1, 2'd1, 1, 0, 0, 0, 0, 0, 0, 4'b0001, 4'b0001);

        // full sweep of load/store/fetch by permissions on a VS access
        for (int a = 0; a < 3; a++) begin
            for (int p = 0; p < 16; p++) begin
                drive("R6 sweep", 1, a[1:0], 2'd1, 1, 0, 0, 0, p[0], p[1], p[2],
                      p[3:0], 4'(15 - p));
            end
        end

        drive("R1 drain", 0, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 4'b0000, 4'b0000);
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule